// File: doc/BRIEF.md
# Command-Queue Serial Flash SPI Sequencer

This block is a single-lane SPI master for serial NAND flash in which software never toggles pins directly. The host queues operation words, and each word names an action and a byte count. Four actions exist: release chip select, assert chip select, shift bytes out, and shift bytes in. A sequencer takes the words from an operation queue in order and runs them on the SPI pins. Bytes to send and bytes received both pass through one byte-wide data queue that the host fills or drains.

A complete flash command is written as a series of words. The host asserts chip select, transmits the opcode, transmits the address and the dummy bytes, then either transmits or receives the data, and finally releases chip select. The sequencer pauses the serial clock whenever it cannot continue without losing a byte. It also reports when everything queued has finished, so the host can tell that the flash command is complete.

Top module: `spi_opq_seq`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, op_empty is 1, op_full is 0, df_empty is 1 and df_full is 0.
- R2: An operation word carries the byte count in bits [8:0] and the op code in bits [13:9]. op_stage_we loads op_wdata into a staging register. op_push queues the staged word, and queues it again on every later op_push until the staging register is written again.
- R3: The operation queue holds 8 words. op_full rises once 8 words are waiting, and a push while full is discarded.
- R4: Op code 0x1 drives cs_n to 0 and op code 0x0 drives cs_n to 1. cs_n changes at no other time.
- R5: Op codes 0x8 and 0x11 each transmit count bytes taken in order from the data queue. The bytes are sent MSB first in SPI mode 0: sck idles low, and mosi is stable at each rising edge.
- R6: Op code 0xC receives count bytes. miso is sampled at each rising edge of sck, MSB first, and each completed byte is appended to the data queue.
- R7: Each high phase and each low phase of sck inside a byte lasts clk_div+1 system clock cycles.
- R8: A transmit op that needs a byte while the data queue is empty, and a receive op that has a completed byte while the data queue is full, both hold sck low until the condition clears. No byte is lost.
- R9: The data queue holds 16 bytes and shows its head on df_rdata. df_pop advances the head. A push while full is discarded and a pop while empty is discarded.
- R10: While manual_en is 0, no queued operation starts.
- R11: op_empty is 1 only when the operation queue is empty and no operation is executing.
- R12: A host push and a host pop of the data queue in the same cycle both take effect when the queue is neither empty nor full. When the queue is full, the push is discarded and the pop still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| manual_en | input | 1 | Allows queued operations to start |
| clk_div | input | 8 | Sets each sck phase to clk_div+1 cycles |
| op_wdata | input | 14 | Operation word for the staging register |
| op_stage_we | input | 1 | Loads op_wdata into the staging register |
| op_push | input | 1 | Queues the staged operation word |
| op_full | output | 1 | Operation queue full |
| op_empty | output | 1 | Nothing queued and nothing executing |
| df_wdata | input | 8 | Byte pushed by the host |
| df_push | input | 1 | Host push strobe for the data queue |
| df_pop | input | 1 | Host pop strobe for the data queue |
| df_rdata | output | 8 | Head byte of the data queue |
| df_full | output | 1 | Data queue full |
| df_empty | output | 1 | Data queue empty |
| sck | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI serial data out |
| miso | input | 1 | SPI serial data in |

## Verification
The data queue can receive a host push and a host pop in the same cycle. The bench provokes this by raising both strobes together, once with one byte stored and once with all sixteen stored. It judges the outcome by draining the queue afterwards and comparing the sequence and number of bytes that come out. A second coincidence occurs when the sequencer is waiting on the data queue. It resumes in the cycle after the host relieves the queue, and the bench judges that resumption by counting sck edges before and after the host acts.

// File: rtl/spi_opq_pkg.sv
package spi_opq_pkg;

    localparam int CNT_W  = 9;
    localparam int CODE_W = 5;
    localparam int WORD_W = CNT_W + CODE_W;

    typedef enum logic [CODE_W-1:0] {
        OPC_CS_HIGH = 5'h00,
        OPC_CS_LOW  = 5'h01,
        OPC_TX      = 5'h08,
        OPC_RX      = 5'h0C,
        OPC_TX_ALT  = 5'h11
    } op_code_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  count;
    } op_word_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_TXLOAD,
        S_SHIFT,
        S_RXPUSH
    } seq_state_e;

    function automatic logic code_is_tx(input logic [CODE_W-1:0] c);
        return (c == OPC_TX) || (c == OPC_TX_ALT);
    endfunction

endpackage

// File: rtl/spi_opq_fifo.sv
module spi_opq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [AW:0]      cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == FULL_CNT);
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_q] <= din;
                wr_q        <= wr_q + 1'b1;
            end
            if (do_pop)
                rd_q <= rd_q + 1'b1;
            if (do_push && !do_pop)
                cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    a_r9_full_blocks_push: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (full && $stable(cnt_q)));

    a_r9_empty_blocks_pop: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/spi_opq_clkgen.sv
module spi_opq_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/spi_opq_engine.sv
module spi_opq_engine
    import spi_opq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              manual_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              op_valid,
    input  op_word_t          op_word,
    output logic              op_pop,
    input  logic              df_empty,
    input  logic              df_full,
    input  logic [7:0]        df_head,
    output logic              df_pop,
    output logic              df_push,
    output logic [7:0]        df_push_data,
    output logic              busy,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    seq_state_e       state_q;
    op_word_t         op_q;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       sh_q;
    logic [2:0]       bit_q;
    logic             rbit_q, sck_q, cs_q, tx_q, tick;
    logic             last_byte;

    spi_opq_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == S_SHIFT),
        .div  (clk_div),
        .tick (tick)
    );

    assign op_pop       = (state_q == S_IDLE) && manual_en && op_valid;
    assign df_pop       = (state_q == S_TXLOAD) && !df_empty;
    assign df_push      = (state_q == S_RXPUSH) && !df_full;
    assign df_push_data = sh_q;
    assign busy         = (state_q != S_IDLE);
    assign sck          = sck_q;
    assign cs_n         = cs_q;
    assign mosi         = (tx_q && state_q == S_SHIFT) ? sh_q[7] : 1'b0;
    assign last_byte    = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            cnt_q   <= '0;
            sh_q    <= '0;
            bit_q   <= '0;
            rbit_q  <= 1'b0;
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            tx_q    <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (op_pop) begin
                        op_q    <= op_word;
                        state_q <= S_DECODE;
                    end
                end
                S_DECODE: begin
                    bit_q <= '0;
                    cnt_q <= op_q.count;
                    case (op_q.code)
                        OPC_CS_HIGH: begin
                            cs_q    <= 1'b1;
                            state_q <= S_IDLE;
                        end
                        OPC_CS_LOW: begin
                            cs_q    <= 1'b0;
                            state_q <= S_IDLE;
                        end
                        OPC_RX: begin
                            tx_q    <= 1'b0;
                            state_q <= (op_q.count == '0) ? S_IDLE : S_SHIFT;
                        end
                        default: begin
                            if (code_is_tx(op_q.code)) begin
                                tx_q    <= 1'b1;
                                state_q <= (op_q.count == '0) ? S_IDLE : S_TXLOAD;
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end
                    endcase
                end
                S_TXLOAD: begin
                    if (df_pop) begin
                        sh_q    <= df_head;
                        bit_q   <= '0;
                        state_q <= S_SHIFT;
                    end
                end
                S_SHIFT: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q  <= 1'b1;
                            rbit_q <= miso;
                        end else begin
                            sck_q <= 1'b0;
                            sh_q  <= {sh_q[6:0], rbit_q};
                            bit_q <= bit_q + 1'b1;
                            if (bit_q == 3'd7) begin
                                if (tx_q) begin
                                    cnt_q   <= cnt_q - 1'b1;
                                    state_q <= last_byte ? S_IDLE : S_TXLOAD;
                                end else begin
                                    state_q <= S_RXPUSH;
                                end
                            end
                        end
                    end
                end
                S_RXPUSH: begin
                    if (df_push) begin
                        cnt_q   <= cnt_q - 1'b1;
                        state_q <= last_byte ? S_IDLE : S_SHIFT;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R4: chip select moves only when a chip-select word is decoded
    a_r4_cs_only_on_decode: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_DECODE) |=> $stable(cs_q));

    // R8: a stalled sequencer keeps the serial clock low
    a_r8_stall_sck_low: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_TXLOAD || state_q == S_RXPUSH) |-> !sck_q);

    // R10: nothing leaves idle while manual mode is off
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && !manual_en) |=> (state_q == S_IDLE));

endmodule

// File: rtl/spi_opq_seq.sv
module spi_opq_seq
    import spi_opq_pkg::*;
#(
    parameter int OPQ_DEPTH = 8,
    parameter int DFQ_DEPTH = 16,
    parameter int DIV_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              manual_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [WORD_W-1:0] op_wdata,
    input  logic              op_stage_we,
    input  logic              op_push,
    output logic              op_full,
    output logic              op_empty,
    input  logic [7:0]        df_wdata,
    input  logic              df_push,
    input  logic              df_pop,
    output logic [7:0]        df_rdata,
    output logic              df_full,
    output logic              df_empty,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    op_word_t   stage_q;
    op_word_t   q_head;
    logic       q_empty, eng_op_pop, busy;
    logic       eng_df_pop, eng_df_push;
    logic [7:0] eng_df_data;

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else if (op_stage_we)
            stage_q <= op_word_t'(op_wdata);
    end

    spi_opq_fifo #(.WIDTH(WORD_W), .DEPTH(OPQ_DEPTH)) u_opq (
        .clk   (clk),
        .rst   (rst),
        .push  (op_push),
        .din   (stage_q),
        .pop   (eng_op_pop),
        .dout  (q_head),
        .full  (op_full),
        .empty (q_empty)
    );

    spi_opq_fifo #(.WIDTH(8), .DEPTH(DFQ_DEPTH)) u_dfq (
        .clk   (clk),
        .rst   (rst),
        .push  (eng_df_push | df_push),
        .din   (eng_df_push ? eng_df_data : df_wdata),
        .pop   (eng_df_pop | df_pop),
        .dout  (df_rdata),
        .full  (df_full),
        .empty (df_empty)
    );

    spi_opq_engine #(.DIV_W(DIV_W)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .manual_en    (manual_en),
        .clk_div      (clk_div),
        .op_valid     (!q_empty),
        .op_word      (q_head),
        .op_pop       (eng_op_pop),
        .df_empty     (df_empty),
        .df_full      (df_full),
        .df_head      (df_rdata),
        .df_pop       (eng_df_pop),
        .df_push      (eng_df_push),
        .df_push_data (eng_df_data),
        .busy         (busy),
        .sck          (sck),
        .cs_n         (cs_n),
        .mosi         (mosi),
        .miso         (miso)
    );

    assign op_empty = q_empty && !busy;

    // R11: when everything is reported finished the bus is quiet
    a_r11_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        op_empty |-> !sck);

    // R3: a full operation queue cannot be reported empty
    a_r3_full_not_empty: assert property (@(posedge clk) disable iff (rst)
        op_full |-> !op_empty);

endmodule

// File: tb/tb_spi_opq_seq.sv
module tb_spi_opq_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        manual_en = 1'b0;
    logic [7:0]  clk_div = 8'd0;
    logic [13:0] op_wdata = '0;
    logic        op_stage_we = 1'b0, op_push = 1'b0;
    logic        op_full, op_empty;
    logic [7:0]  df_wdata = '0;
    logic        df_push = 1'b0, df_pop = 1'b0;
    logic [7:0]  df_rdata;
    logic        df_full, df_empty;
    logic        sck, cs_n, mosi, miso;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    spi_opq_seq dut (
        .clk(clk), .rst(rst), .manual_en(manual_en), .clk_div(clk_div),
        .op_wdata(op_wdata), .op_stage_we(op_stage_we), .op_push(op_push),
        .op_full(op_full), .op_empty(op_empty),
        .df_wdata(df_wdata), .df_push(df_push), .df_pop(df_pop),
        .df_rdata(df_rdata), .df_full(df_full), .df_empty(df_empty),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // SPI-side model: captures mosi and serves miso per rising edge
    int         rises = 0;
    int         nbytes = 0;
    logic [7:0] msh = '0;
    logic [7:0] mon [64];
    logic       cs_at_rise = 1'b1;

    function automatic logic [7:0] rxb(input int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    assign miso = rxb(rises / 8)[7 - (rises % 8)];

    always @(posedge sck) begin
        msh = {msh[6:0], mosi};
        cs_at_rise = cs_n;
        if (rises % 8 == 7) begin
            if (nbytes < 64) mon[nbytes] = msh;
            nbytes = nbytes + 1;
        end
        rises = rises + 1;
    end

    task automatic clr_mon();
        rises = 0;
        nbytes = 0;
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic op_q(input logic [4:0] code, input logic [8:0] cnt);
        @(negedge clk);
        op_wdata = {code, cnt};
        op_stage_we = 1'b1;
        @(negedge clk);
        op_stage_we = 1'b0;
        op_push = 1'b1;
        @(negedge clk);
        op_push = 1'b0;
    endtask

    task automatic op_repush();
        @(negedge clk);
        op_push = 1'b1;
        @(negedge clk);
        op_push = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        df_wdata = b;
        df_push = 1'b1;
        @(negedge clk);
        df_push = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        @(negedge clk);
        b = df_rdata;
        df_pop = 1'b1;
        @(negedge clk);
        df_pop = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (op_empty) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int n;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(cs_n == 1 && sck == 0, "R1 pins", {cs_n, sck}, 2);
        chk(op_empty && !op_full && df_empty && !df_full, "R1 flags",
            {op_empty, op_full, df_empty, df_full}, 4'b1010);

        // R9 depth, ordering, overflow and underflow
        for (int i = 0; i < 17; i++) put(8'(i + 100));
        chk(df_full == 1, "R9 full after 16", df_full, 1);
        for (int i = 0; i < 16; i++) begin
            get(b);
            chk(b == 8'(i + 100), "R9 order", b, i + 100);
        end
        chk(df_empty == 1, "R9 empty after drain", df_empty, 1);
        get(b);
        put(8'h5A);
        get(b);
        chk(b == 8'h5A && df_empty, "R9 pop on empty ignored", b, 8'h5A);

        // R12 push and pop in one cycle
        put(8'h11);
        @(negedge clk);
        df_wdata = 8'h22; df_push = 1'b1; df_pop = 1'b1;
        @(negedge clk);
        df_push = 1'b0; df_pop = 1'b0;
        chk(df_rdata == 8'h22 && !df_empty, "R12 one entry", df_rdata, 8'h22);
        get(b);
        chk(df_empty == 1, "R12 single left", df_empty, 1);
        for (int i = 0; i < 16; i++) put(8'(i));
        @(negedge clk);
        df_wdata = 8'hEE; df_push = 1'b1; df_pop = 1'b1;
        @(negedge clk);
        df_push = 1'b0; df_pop = 1'b0;
        n = 0;
        for (int i = 1; i < 16; i++) begin
            get(b);
            if (b != 8'(i)) n++;
        end
        chk(n == 0 && df_empty, "R12 full push dropped", n, 0);

        // R4 chip select words
        manual_en = 1'b1;
        op_q(5'h01, 9'd1);
        wait_done();
        chk(cs_n == 0, "R4 assert", cs_n, 0);
        op_q(5'h00, 9'd1);
        wait_done();
        chk(cs_n == 1, "R4 release", cs_n, 1);

        // R7 and R5 clock divider sweep with op 0x8
        op_q(5'h01, 9'd1);
        for (int d = 0; d < 4; d++) begin
            clk_div = 8'(d);
            clr_mon();
            put(8'(8'hA5 ^ (d * 8'h3C)));
            op_q(5'h08, 9'd1);
            @(posedge sck);
            n = 0;
            while (sck) begin
                @(posedge clk);
                #1;
                n++;
            end
            chk(n == d + 1, "R7 high phase", n, d + 1);
            wait_done();
            chk(nbytes == 1 && mon[0] == 8'(8'hA5 ^ (d * 8'h3C)), "R5 tx byte",
                mon[0], 8'(8'hA5 ^ (d * 8'h3C)));
        end
        chk(cs_at_rise == 0, "R4 cs low during tx", cs_at_rise, 0);

        // R5 alternate transmit op, several bytes
        clk_div = 8'd1;
        clr_mon();
        for (int i = 0; i < 3; i++) put(8'(8'h30 + i * 7));
        op_q(5'h11, 9'd3);
        wait_done();
        n = 0;
        for (int i = 0; i < 3; i++) if (mon[i] != 8'(8'h30 + i * 7)) n++;
        chk(nbytes == 3 && n == 0, "R5 alt op bytes", nbytes, 3);

        // R2 re-push of staged word
        clr_mon();
        put(8'hC3);
        put(8'h3C);
        op_q(5'h08, 9'd1);
        op_repush();
        wait_done();
        chk(nbytes == 2 && mon[0] == 8'hC3 && mon[1] == 8'h3C, "R2 repush", nbytes, 2);

        // R6 receive
        clr_mon();
        op_q(5'h0C, 9'd4);
        wait_done();
        n = 0;
        for (int i = 0; i < 4; i++) begin
            get(b);
            if (b != rxb(i)) n++;
        end
        chk(n == 0 && df_empty, "R6 rx bytes", n, 0);

        // R8 transmit stall on empty data queue
        clr_mon();
        put(8'h81);
        op_q(5'h08, 9'd2);
        while (rises < 8) @(negedge clk);
        idle(60);
        chk(rises == 8 && sck == 0 && !op_empty, "R8 tx stall", rises, 8);
        put(8'h7E);
        wait_done();
        chk(rises == 16 && mon[1] == 8'h7E, "R8 tx resume", mon[1], 8'h7E);

        // R8 receive stall on full data queue
        clr_mon();
        for (int i = 0; i < 14; i++) put(8'(i + 1));
        op_q(5'h0C, 9'd3);
        idle(200);
        chk(rises == 24 && df_full && !op_empty, "R8 rx stall", rises, 24);
        get(b);
        wait_done();
        n = 0;
        for (int i = 1; i < 14; i++) begin
            get(b);
            if (b != 8'(i + 1)) n++;
        end
        for (int i = 0; i < 3; i++) begin
            get(b);
            if (b != rxb(i)) n++;
        end
        chk(n == 0 && df_empty, "R8 rx no loss", n, 0);

        // R3 and R10 operation queue depth with manual mode off
        manual_en = 1'b0;
        clr_mon();
        for (int i = 0; i < 9; i++) put(8'(i + 50));
        op_q(5'h08, 9'd1);
        for (int i = 0; i < 8; i++) op_repush();
        chk(op_full == 1, "R3 full at 8", op_full, 1);
        idle(40);
        chk(rises == 0 && !op_empty, "R10 no start", rises, 0);
        chk(op_empty == 0, "R11 pending not empty", op_empty, 0);
        manual_en = 1'b1;
        wait_done();
        chk(nbytes == 8, "R3 ninth push dropped", nbytes, 8);
        get(b);
        chk(b == 8'd58 && df_empty, "R3 leftover byte", b, 58);
        chk(op_empty == 1, "R11 empty when done", op_empty, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule